// File: doc/BRIEF.md
# Euclidean GCD Engine

This block is a small single-purpose processor. It finds the greatest common divisor of two unsigned operands with the remainder form of Euclid's method. A controller state machine drives a datapath. The datapath has two operand registers, a remainder register, a sequential remainder unit and a zero test on the second operand. Each pass of the loop divides the first operand by the second. The old second operand then moves into the first register, and the remainder moves into the second. The loop stops as soon as the second operand is zero, and the first register then holds the answer.

A client drives both operands and pulses `start`. The engine accepts the pulse only while it is idle or finished. It raises `done` when the answer is ready and holds it there until the next accepted start. The remainder unit is a restoring shift-subtract divider that retires one quotient bit per clock.

Top module: `gcd_engine`

## Requirements
- R1: A start sampled high while the engine is idle or finished loads `op_a` into A and `op_b` into B. `done` is low in the cycle after that clock edge.
- R2: When `done` is high, `result` equals the greatest common divisor of the two unsigned WIDTH-bit operands accepted with the last start. The answer comes from repeating A <= B, B <= A mod B until B is zero.
- R3: For operands 48 and 18, the remainder sequence is 12, 6, 0 and the result is 6.
- R4: If B is zero at start, the result is A and no division is performed. In particular, operands 0 and 0 give result 0.
- R5: The remainder unit returns its value after WIDTH shift-subtract steps. Each loop iteration therefore takes WIDTH+3 cycles, and `done` rises exactly 1 + n*(WIDTH+3) clock edges after the accepting edge, where n is the number of nonzero-divisor remainder steps.
- R6: While the engine is finished and `start` is low, `done` stays high and `result` stays unchanged.
- R7: A start pulse that arrives while a computation is running has no effect. That computation finishes with its own result and latency.
- R8: A synchronous reset, `rst` high at a clock edge, returns the controller to idle with `done` low.
- R9: While idle with `start` low, the engine stays idle and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a new computation |
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| result | output | WIDTH | Greatest common divisor, valid while done is high |
| done | output | 1 | High while a finished result is presented |

## Verification
The bound checker watches the controller's sequencing on every cycle. It checks that done drops after an accepted start and holds with a stable result while finished. It checks that a zero second operand at the loop test leads straight to finish, that the remainder unit's valid pulse appears only during the remainder state, and that reset and idle behave as required. The numerical results can only be shown by the bench's scenarios: the gcd values, the exact latency per iteration count, and the fact that a start pulse in mid-run is ignored. These scenarios are directed corner cases together with seeded random operand pairs, each compared with a reference Euclid loop in the bench.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CHECK   = 3'd1,
      ST_REMAIN  = 3'd2,
      ST_UPDATE  = 3'd3,
      ST_FINISH  = 3'd4
   } gcd_state_e;

   typedef struct packed {
      logic ld_ops;   // capture operand inputs into A and B
      logic div_go;   // launch the remainder unit
      logic ld_rem;   // capture the remainder into R
      logic swap;     // A <= B, B <= R
   } gcd_ctl_t;

endpackage

// File: rtl/gcd_rem_unit.sv
module gcd_rem_unit #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             go,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             valid,
   output logic [WIDTH-1:0] remainder
);
   localparam int CW = $clog2(WIDTH + 1);

   logic [WIDTH-1:0] quo_sh;
   logic [WIDTH-1:0] part;
   logic [WIDTH-1:0] dvsr;
   logic [CW-1:0]    steps;
   logic             valid_q;
   logic [WIDTH:0]   trial;
   logic [WIDTH:0]   diff;

   // bring down the next dividend bit, then try to subtract
   assign trial = {part, quo_sh[WIDTH-1]};
   assign diff  = trial - {1'b0, dvsr};

   always_ff @(posedge clk) begin
      if (rst) begin
         quo_sh  <= '0;
         part    <= '0;
         dvsr    <= '0;
         steps   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (go) begin
            quo_sh <= dividend;
            dvsr   <= divisor;
            part   <= '0;
            steps  <= CW'(WIDTH);
         end else if (steps != '0) begin
            // restore on borrow, keep difference otherwise
            part   <= diff[WIDTH] ? trial[WIDTH-1:0] : diff[WIDTH-1:0];
            quo_sh <= {quo_sh[WIDTH-2:0], 1'b0};
            steps  <= steps - 1'b1;
            if (steps == CW'(1)) valid_q <= 1'b1;
         end
      end
   end

   assign valid     = valid_q;
   assign remainder = part;
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
   import gcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       b_zero,
   input  logic       div_valid,
   output gcd_ctl_t   ctl,
   output gcd_state_e state,
   output logic       finished
);
   gcd_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      ctl     = '0;
      unique case (state_q)
         ST_IDLE, ST_FINISH: begin
            if (start) begin
               ctl.ld_ops = 1'b1;
               state_d    = ST_CHECK;
            end
         end
         ST_CHECK: begin
            if (b_zero) begin
               state_d = ST_FINISH;
            end else begin
               ctl.div_go = 1'b1;
               state_d    = ST_REMAIN;
            end
         end
         ST_REMAIN: begin
            if (div_valid) begin
               ctl.ld_rem = 1'b1;
               state_d    = ST_UPDATE;
            end
         end
         ST_UPDATE: begin
            ctl.swap = 1'b1;
            state_d  = ST_CHECK;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign state    = state_q;
   assign finished = (state_q == ST_FINISH);
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
   import gcd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  gcd_ctl_t         ctl,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             b_zero,
   output logic             div_valid,
   output logic [WIDTH-1:0] a_val
);
   logic [WIDTH-1:0] a_q, b_q, r_q;
   logic [WIDTH-1:0] rem_out;

   gcd_rem_unit #(.WIDTH(WIDTH)) u_rem (
      .clk       (clk),
      .rst       (rst),
      .go        (ctl.div_go),
      .dividend  (a_q),
      .divisor   (b_q),
      .valid     (div_valid),
      .remainder (rem_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
         r_q <= '0;
      end else begin
         if (ctl.ld_ops) begin
            a_q <= op_a;
            b_q <= op_b;
         end else if (ctl.swap) begin
            a_q <= b_q;
            b_q <= r_q;
         end
         if (ctl.ld_rem) r_q <= rem_out;
      end
   end

   assign b_zero = (b_q == '0);
   assign a_val  = a_q;
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
   import gcd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] result,
   output logic             done
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gcd_engine: WIDTH must be at least 2");
      end
   endgenerate

   gcd_ctl_t   ctl;
   gcd_state_e state_q;
   logic       b_zero;
   logic       div_valid;

   gcd_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .b_zero    (b_zero),
      .div_valid (div_valid),
      .ctl       (ctl),
      .state     (state_q),
      .finished  (done)
   );

   gcd_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .ctl       (ctl),
      .op_a      (op_a),
      .op_b      (op_b),
      .b_zero    (b_zero),
      .div_valid (div_valid),
      .a_val     (result)
   );
endmodule

// File: rtl/gcd_engine_chk.sv
module gcd_engine_chk
   import gcd_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [WIDTH-1:0] result,
   input logic             done,
   input gcd_state_e       state,
   input logic             b_zero,
   input logic             div_valid
);
   // R1
   start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
      (done && start) |=> !done);

   // R4
   zero_divisor_finishes_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CHECK && b_zero) |=> done);

   // R5
   valid_only_in_remain_chk: assert property (@(posedge clk) disable iff (rst)
      div_valid |-> (state == ST_REMAIN));

   // R5
   remain_waits_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_REMAIN && !div_valid) |=> (state == ST_REMAIN));

   // R6
   finish_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> (done && $stable(result)));

   // R8
   reset_to_idle_chk: assert property (@(posedge clk)
      rst |=> (!done && state == ST_IDLE));

   // R9
   idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && !start) |=> (state == ST_IDLE && !done));
endmodule

bind gcd_engine gcd_engine_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .result    (result),
   .done      (done),
   .state     (state_q),
   .b_zero    (b_zero),
   .div_valid (div_valid)
);

// File: tb/test_gcd_engine.sv
module test_gcd_engine;
   localparam int W    = 8;
   localparam int ITER = W + 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] result;
   logic         done;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   gcd_engine #(.WIDTH(W)) i_gcd_engine (
      .clk(clk), .rst(rst), .start(start),
      .op_a(op_a), .op_b(op_b), .result(result), .done(done)
   );

   function automatic int ref_gcd(input int a, input int b);
      int x = a, y = b, t;
      while (y != 0) begin t = x % y; x = y; y = t; end
      return x;
   endfunction

   function automatic int ref_steps(input int a, input int b);
      int x = a, y = b, t, n = 0;
      while (y != 0) begin t = x % y; x = y; y = t; n++; end
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // pulse start so that it is sampled at the next rising edge
   task automatic pulse_start(input int a, input int b);
      @(negedge clk);
      op_a  = W'(a);
      op_b  = W'(b);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
   endtask

   task automatic wait_done(output int cnt);
      cnt = 0;
      while (!done && cnt < 5000) begin
         @(posedge clk); #1; cnt++;
      end
   endtask

   task automatic run(input int a, input int b, input string req);
      int cnt, exp_r, exp_lat;
      logic [W-1:0] held;
      exp_r   = ref_gcd(a, b);
      exp_lat = 1 + ref_steps(a, b) * ITER;
      pulse_start(a, b);
      check(done == 1'b0, "R1 done low after accepted start", int'(done), 0);
      wait_done(cnt);
      check(result == W'(exp_r), {req, " result"}, int'(result), exp_r);
      check(cnt == exp_lat, "R5 latency", cnt, exp_lat);
      held = result;
      repeat (3) @(posedge clk);
      #1;
      check(done && result == held, "R6 hold while finished", int'(result), int'(held));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int cnt;
      void'($urandom(32'h5EED_0C0D));
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      check(done == 1'b0, "R8 reset state", int'(done), 0);
      repeat (10) @(posedge clk);
      #1 check(done == 1'b0, "R9 idle without start", int'(done), 0);

      run(48, 18, "R3");
      run(18, 48, "R2");
      run(77, 0, "R4");
      run(0, 0, "R4");
      run(0, 35, "R2");
      run(255, 255, "R2");
      run(1, 255, "R2");
      run(255, 1, "R2");
      run(128, 64, "R2");
      run(233, 144, "R2");

      // R7: start in mid-run ignored
      pulse_start(48, 18);
      repeat (5) @(posedge clk);
      pulse_start(7, 3);
      wait_done(cnt);
      check(result == W'(6), "R7 result unaffected", int'(result), 6);
      check(cnt == 1 + 3 * ITER - 6, "R7 latency unaffected", cnt, 1 + 3 * ITER - 6);

      // R8: reset mid-run, then R9 idle
      pulse_start(200, 75);
      repeat (4) @(posedge clk);
      @(negedge clk) rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      check(done == 1'b0, "R8 reset mid-run", int'(done), 0);
      repeat (60) @(posedge clk);
      #1 check(done == 1'b0, "R9 stays idle after reset", int'(done), 0);

      for (int i = 0; i < 200; i++) begin
         int a, b;
         a = int'($urandom() % 256);
         b = int'($urandom() % 256);
         if (i % 17 == 0) b = 0;
         run(a, b, "R2");
      end
      finish_run();
   end
endmodule